// File: doc/BRIEF.md
# Product-Data Capability Access Controller

This block is one entry in a function's configuration-space capability list. Through it, software reads and writes product-identification data kept in an external storage device, one 32-bit word at a time. The entry has two dwords. The first holds the capability header and an address field. The address field carries a completion flag in its top bit. The second dword holds a 32-bit data window.

To start a fetch, software writes a word address with the flag at 0. It then polls until the flag reads 1, and the fetched word is in the data window. To start a store, software first fills the data window. It then writes the address with the flag at 1 and polls until the flag reads 0.

On the storage side, the block drives one request and waits for one acknowledge per word. A single flag bit carries both the direction of the transfer and its completion. The serial protocol of the storage device and the meaning of the stored data are handled outside this block.

Top module: `vpd_cap_ctrl`

## Requirements
- R1: Dword 0 reads capability ID 0x03 in bits [7:0] and the NEXT_PTR parameter in bits [15:8]. A NEXT_PTR of zero marks the last entry of the list.
- R2: After reset, the flag, the address field and the data window all read 0, and `memReq` is low.
- R3: A write to dword 0 starts a fetch when byte lane 3 is enabled and bit 31 is 0. In the next cycle `memReq` is 1, `memWe` is 0, and `memAddr` equals the address field.
- R4: When a fetch is acknowledged, `memRdata` is loaded into the data window. From the following cycle the flag reads 1 and `memReq` is low.
- R5: A write to dword 0 starts a store when byte lane 3 is enabled and bit 31 is 1. The store has `memWe` = 1 and `memWdata` equal to the data window. Once it is acknowledged, the flag reads 0 and `memReq` is low.
- R6: The address field is 15 bits wide and sits at bits [30:16]. Its two lowest bits are always 0, so the storage address is always 4-byte aligned.
- R7: While a transfer is pending, writes to either dword are ignored, and reads return the current field values.
- R8: While a transfer is in flight, the flag keeps the value that was written with the address.
- R9: Writes to the data window update only the enabled byte lanes. A write to dword 0 without lane 3 enabled updates the low address byte but starts nothing.
- R10: While `memReq` is high and not yet acknowledged, `memAddr`, `memWe` and `memWdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Configuration write strobe |
| cfgDwordSel | input | 1 | Dword select: 0 = header/address dword, 1 = data dword |
| cfgByteEn | input | 4 | Byte-lane enables for the write |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Read value of the selected dword |
| memReq | output | 1 | Storage request, held until acknowledged |
| memWe | output | 1 | Storage direction: 1 = store, 0 = fetch |
| memAddr | output | 15 | Storage byte address, 4-byte aligned |
| memWdata | output | 32 | Word to be stored |
| memRdata | input | 32 | Fetched word, valid together with `memAck` |
| memAck | input | 1 | Storage acknowledge for the pending request |

## Verification
The bench builds the block with NEXT_PTR = 0x48. A nonzero pointer makes the pointer byte observable and distinct from the capability ID, which the default value would hide. The address width stays at its default of 15 bits. This makes the address field fill bits [30:16] exactly, so addresses at the top of the range (0x7FFF, which reads back as 0x7FFC) test both the alignment rule and the upper boundary of the field. The acknowledge delay varies from 0 to several cycles, so the flag-hold rule and the request-stability rule are tested across long flights as well as immediate acknowledges.

// File: rtl/vpd_cap_pkg.sv
package vpd_cap_pkg;

  localparam logic [7:0] CAP_ID = 8'h03;

  // Strobes from control to datapath
  typedef struct packed {
    logic addrLoad;   // accept a dword-0 write
    logic dataLoad;   // accept a dword-1 write
    logic rdCapture;  // latch fetched word
    logic flagFlip;   // invert flag on completion
  } vpdStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } vpdState_t;

endpackage

// File: rtl/vpd_cap_control.sv
module vpd_cap_control
  import vpd_cap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWr,
  input  logic     cfgDwordSel,
  input  logic     startLane,
  input  logic     dirBit,
  input  logic     memAck,
  output vpdStrb_t strb,
  output logic     memReq,
  output logic     memWe
);

  vpdState_t stateQ, stateD;
  logic      idle;

  assign idle = (stateQ == ST_IDLE);

  always_comb begin
    strb.addrLoad  = cfgWr && !cfgDwordSel && idle;
    strb.dataLoad  = cfgWr && cfgDwordSel && idle;
    strb.rdCapture = (stateQ == ST_RD) && memAck;
    strb.flagFlip  = !idle && memAck;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (strb.addrLoad && startLane) stateD = dirBit ? ST_WR : ST_RD;
      ST_RD:   if (memAck) stateD = ST_IDLE;
      ST_WR:   if (memAck) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq = !idle;
  assign memWe  = (stateQ == ST_WR);

endmodule

// File: rtl/vpd_cap_datapath.sv
module vpd_cap_datapath
  import vpd_cap_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter int         DATA_W   = 32,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  vpdStrb_t          strb,
  input  logic              cfgDwordSel,
  input  logic [DATA_W/8-1:0] cfgByteEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] cfgRdData,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              flagQ
);

  localparam int LANES  = DATA_W / 8;
  localparam int HI_W   = ADDR_W - 8;

  // Data window, one register per byte lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 dataQ[g*8 +: 8] <= '0;
      else if (strb.rdCapture)                   dataQ[g*8 +: 8] <= memRdata[g*8 +: 8];
      else if (strb.dataLoad && cfgByteEn[g])    dataQ[g*8 +: 8] <= cfgWrData[g*8 +: 8];
    end
  end

  // Address field: lane 2 -> low byte (aligned), lane 3 -> high bits + flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (strb.addrLoad && cfgByteEn[2])
        addrQ[7:0] <= {cfgWrData[23:18], 2'b00};
      if (strb.addrLoad && cfgByteEn[3]) begin
        addrQ[ADDR_W-1:8] <= cfgWrData[24 +: HI_W];
        flagQ             <= cfgWrData[31];
      end else if (strb.flagFlip) begin
        flagQ <= !flagQ;
      end
    end
  end

  assign cfgRdData = cfgDwordSel ? dataQ : {flagQ, addrQ, NEXT_PTR, CAP_ID};

endmodule

// File: rtl/vpd_cap_ctrl.sv
module vpd_cap_ctrl
  import vpd_cap_pkg::*;
#(
  parameter logic [7:0] NEXT_PTR = 8'h00,
  parameter int         ADDR_W   = 15,
  parameter int         DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgDwordSel,
  input  logic [3:0]        cfgByteEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  vpdStrb_t          strb;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              flagQ;

  vpd_cap_control i_control (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWr       (cfgWr),
    .cfgDwordSel (cfgDwordSel),
    .startLane   (cfgByteEn[3]),
    .dirBit      (cfgWrData[31]),
    .memAck      (memAck),
    .strb        (strb),
    .memReq      (memReq),
    .memWe       (memWe)
  );

  vpd_cap_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NEXT_PTR (NEXT_PTR)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgDwordSel (cfgDwordSel),
    .cfgByteEn   (cfgByteEn),
    .cfgWrData   (cfgWrData),
    .memRdata    (memRdata),
    .cfgRdData   (cfgRdData),
    .addrQ       (addrQ),
    .dataQ       (dataQ),
    .flagQ       (flagQ)
  );

  assign memAddr  = addrQ;
  assign memWdata = dataQ;

endmodule

// File: rtl/vpd_cap_checker.sv
module vpd_cap_checker #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] dataQ,
  input logic              flagQ
);

  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R6
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(flagQ));

  // R4
  rd_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> (flagQ && !memReq));

  // R5
  wr_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (!flagQ && !memReq));

  // R7
  data_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(dataQ));

endmodule

bind vpd_cap_ctrl vpd_cap_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .dataQ    (dataQ),
  .flagQ    (flagQ)
);

// File: tb/test_vpd_cap_ctrl.sv
module test_vpd_cap_ctrl;

  localparam logic [7:0] NEXT_PTR = 8'h48;
  localparam int         CYC      = 10;
  localparam int         NOPS     = 6;

  // {isWrite, addr[14:0], wdata, rdata, ackDelay}
  localparam logic [83:0] OP_TABLE [NOPS] = '{
    {1'b0, 15'h0123, 32'h0000_0000, 32'hA5A5_1234, 4'd0},
    {1'b1, 15'h0040, 32'hDEAD_BEEF, 32'h0000_0000, 4'd2},
    {1'b0, 15'h7FFF, 32'h0000_0000, 32'h0BAD_F00D, 4'd5},
    {1'b1, 15'h7FFE, 32'h1357_9BDF, 32'h0000_0000, 4'd0},
    {1'b0, 15'h0002, 32'h0000_0000, 32'hFFFF_FFFF, 4'd3},
    {1'b1, 15'h2AA9, 32'h0000_0001, 32'h0000_0000, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWr = 1'b0;
  logic        cfgDwordSel = 1'b0;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        memReq, memWe;
  logic [14:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  int checkCount = 0;
  int failCount  = 0;

  always #(CYC/2) clk = ~clk;

  vpd_cap_ctrl #(.NEXT_PTR(NEXT_PTR)) i_vpd_cap_ctrl (
    .clk, .rstN, .cfgWr, .cfgDwordSel, .cfgByteEn, .cfgWrData, .cfgRdData,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWr = 1'b1; cfgDwordSel = sel; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWr = 1'b0; cfgByteEn = 4'h0;
  endtask

  task automatic cfgRead(input logic sel, output logic [31:0] v);
    cfgDwordSel = sel;
    #1;
    v = cfgRdData;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(CYC * 100000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] dataShadow;
    logic [14:0] addrShadow;

    repeat (3) @(negedge clk);
    // R2 reset state
    cfgRead(1'b0, rd);
    check("R2 reset dword0", rd, {16'h0000, NEXT_PTR, 8'h03});
    cfgRead(1'b1, rd);
    check("R2 reset data", rd, 32'h0);
    check("R2 reset memReq", {31'h0, memReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 header
    cfgRead(1'b0, rd);
    check("R1 cap id", {24'h0, rd[7:0]}, 32'h03);
    check("R1 next ptr", {24'h0, rd[15:8]}, {24'h0, NEXT_PTR});

    // Table-driven transfers (R3 R4 R5 R6 R8)
    for (int i = 0; i < NOPS; i++) begin
      logic        isWr;
      logic [14:0] a, aAl;
      logic [31:0] wd, rdm, expData;
      int          dly;
      isWr = OP_TABLE[i][83];
      a    = OP_TABLE[i][82:68];
      wd   = OP_TABLE[i][67:36];
      rdm  = OP_TABLE[i][35:4];
      dly  = int'(OP_TABLE[i][3:0]);
      aAl  = {a[14:2], 2'b00};
      if (isWr) cfgWrite(1'b1, 4'hF, wd);
      cfgWrite(1'b0, 4'hC, {isWr, a, 16'h0000});
      check(isWr ? "R5 req" : "R3 req", {31'h0, memReq}, 32'h1);
      check(isWr ? "R5 we" : "R3 we", {31'h0, memWe}, {31'h0, isWr});
      check("R6 memAddr aligned", {17'h0, memAddr}, {17'h0, aAl});
      if (isWr) check("R5 wdata", memWdata, wd);
      cfgRead(1'b0, rd);
      check("R8 flag at start", {31'h0, rd[31]}, {31'h0, isWr});
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        cfgRead(1'b0, rd);
        check("R8 flag in flight", {31'h0, rd[31]}, {31'h0, isWr});
        check("R10 req held", {31'h0, memReq}, 32'h1);
      end
      memAck = 1'b1; memRdata = rdm;
      @(negedge clk);
      memAck = 1'b0; memRdata = 32'h0;
      expData = isWr ? wd : rdm;
      cfgRead(1'b0, rd);
      check(isWr ? "R5 flag cleared" : "R4 flag set", {31'h0, rd[31]}, {31'h0, !isWr});
      check("R6 addr readback", {17'h0, rd[30:16]}, {17'h0, aAl});
      check(isWr ? "R5 req dropped" : "R4 req dropped", {31'h0, memReq}, 32'h0);
      cfgRead(1'b1, rd);
      check(isWr ? "R5 data kept" : "R4 data loaded", rd, expData);
    end

    // R9 partial data lanes (data currently 0000_0001)
    cfgWrite(1'b1, 4'b0101, 32'h1122_3344);
    cfgRead(1'b1, rd);
    check("R9 data lanes", rd, 32'h0022_0044);
    // R9 address low byte only, no start (address currently 2AA8)
    cfgWrite(1'b0, 4'b0100, 32'h80FF_0000);
    check("R9 no start", {31'h0, memReq}, 32'h0);
    cfgRead(1'b0, rd);
    check("R9 addr low byte", {16'h0, rd[31:16]}, {16'h0, 1'b0, 15'h2AFC});

    // R7 writes ignored while pending
    cfgWrite(1'b1, 4'hF, 32'hCAFE_0001);
    cfgWrite(1'b0, 4'hC, {1'b1, 15'h0100, 16'h0});
    dataShadow = 32'hCAFE_0001;
    addrShadow = 15'h0100;
    cfgWrite(1'b1, 4'hF, 32'h5555_AAAA);
    cfgWrite(1'b0, 4'hC, {1'b0, 15'h1234, 16'h0});
    check("R7 memWdata", memWdata, dataShadow);
    check("R7 memAddr", {17'h0, memAddr}, {17'h0, addrShadow});
    check("R7 memWe", {31'h0, memWe}, 32'h1);
    cfgRead(1'b1, rd);
    check("R7 data readback", rd, dataShadow);
    cfgRead(1'b0, rd);
    check("R7 dword0 readback", {16'h0, rd[31:16]}, {16'h0, 1'b1, addrShadow});
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    cfgRead(1'b0, rd);
    check("R7 completes", {31'h0, rd[31]}, 32'h0);

    // R2 reset mid-flight
    cfgWrite(1'b0, 4'hC, {1'b0, 15'h0010, 16'h0});
    rstN = 1'b0;
    @(negedge clk);
    cfgRead(1'b0, rd);
    check("R2 reset clears", rd, {16'h0000, NEXT_PTR, 8'h03});
    check("R2 reset req", {31'h0, memReq}, 32'h0);
    cfgRead(1'b1, rd);
    check("R2 reset data clears", rd, 32'h0);

    finishRun();
  end

endmodule